// File: doc/BRIEF.md
# Path-Matched Trace Cache

This block keeps recently executed dynamic instruction runs, called traces, so that a fetch unit can deliver several basic blocks in one lookup. Each stored line holds up to sixteen instructions across at most three basic blocks. A line is named by the address of its first instruction and by the directions taken at its first two branches. For every block the line also records the index of the block's last instruction. It keeps, for each branch, the address on the side the trace did not follow, and it keeps the address that follows the whole trace.

The fetch unit gives the fetch address and the predicted directions of the coming branches. One cycle later the block answers in one of three ways. A full hit returns the whole trace. A partial hit returns the leading blocks up to and including the block that ends in the first mispredicted branch. A miss tells the fetch unit to read from the instruction cache. Every answer carries an instruction count and the next fetch address. Each set has two ways, so two traces that begin at the same address but follow different paths can be held together. A separate interface writes a finished trace, built elsewhere, in one cycle.

Top module: `trace_path_cache`

## Requirements
- R1: Every cycle with `lk_valid` high produces exactly one response, with `rsp_valid` high in the following cycle. No response appears without a request.
- R2: A full hit (`rsp_kind` = 2) occurs when a valid way holds a start address equal to `lk_addr` and, for every branch i below the line's stored branch count, `lk_pred[i]` equals stored flag i (1 = taken). Its count is the final block's end index plus one, and its next address is the line's continuation address.
- R3: On a partial hit (`rsp_kind` = 1) the first mismatching branch j sets the result. The count is block j's end index plus one, and the next address is the stored alternate address of branch j, which is the target in the predicted direction.
- R4: Prediction bits at positions equal to or above a line's branch count do not affect its match.
- R5: A miss (`rsp_kind` = 0) returns a count of zero and a next address equal to the lookup address.
- R6: Two traces with the same start address and different branch flags are held at the same time, one in each way of the set. The set is selected by `lk_addr[3:2]`.
- R7: When both ways match, a full hit beats a partial hit. Among partial hits, more matching leading branches wins. Way 0 wins a tie.
- R8: A fill whose address, branch count and relevant flags equal those of a valid line overwrites that line's way.
- R9: Any other fill goes to the first invalid way. When both ways are valid it goes to the least recently used way. A hit marks the chosen way most recent, and so does a fill.
- R10: When a fill and a lookup address the same set in the same cycle, `fill_ready` is low and the fill is not written. The held fill is written in the next cycle.
- R11: After reset every line is invalid and `rsp_valid` is low.
- R12: Slot i of `rsp_insns` (bits i*32 and up) holds instruction i of the chosen trace for i below the count. Every slot from the count upward is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch address to look up |
| lk_pred | input | M_BLK-1 | Predicted directions; bit i is branch i, 1 = taken |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_kind | output | 2 | 0 miss, 1 partial hit, 2 full hit |
| rsp_count | output | clog2(N_INSN+1) | Number of instructions delivered |
| rsp_next | output | ADDR_W | Next fetch address |
| rsp_insns | output | N_INSN*INSN_W | Delivered instructions; slot 0 in the low bits |
| fill_valid | input | 1 | Fill request, held until accepted |
| fill_ready | output | 1 | Fill accepted in this cycle |
| fill_addr | input | ADDR_W | Start address of the trace |
| fill_nbr | input | clog2(M_BLK) | Number of branches inside the trace |
| fill_flags | input | M_BLK-1 | Direction followed at each branch |
| fill_bend | input | M_BLK*clog2(N_INSN) | End index of each block, block 0 in the low bits |
| fill_alt | input | (M_BLK-1)*ADDR_W | Off-path address of each branch |
| fill_cont | input | ADDR_W | Address following the whole trace |
| fill_insns | input | N_INSN*INSN_W | Instruction words, slot 0 in the low bits |

## Verification
The checks assume the fill side holds `fill_valid` and its fields steady while `fill_ready` is low. They also assume `fill_nbr` never exceeds two and that the block end indices rise from block to block. The directed fills in the bench keep to these rules. They raise `fill_valid` for exactly one accepting cycle, or keep it raised through the one collision cycle, and they always give ordered end indices. Lookups may land on any set at any time, so the bench drives the collision case deliberately and does not avoid it.

// File: rtl/tc_pkg.sv
// Shared definitions for the trace cache.
// Assumes: included first in compile order.
package tc_pkg;
    // Response classification carried on rsp_kind.
    typedef enum logic [1:0] {
        TC_MISS = 2'd0,
        TC_PART = 2'd1,
        TC_FULL = 2'd2
    } tc_kind_e;
endpackage

// File: rtl/tc_way.sv
// One way of the trace store: per-set valid bits plus line fields.
// Has a lookup read port, a probe read port used for fill placement,
// and a single whole-line write port.
// Assumes: SETS is a power of two and at least 2.
module tc_way #(
    parameter int SETS   = 4,
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32,
    parameter int N_INSN = 16,
    parameter int M_BLK  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(SETS)-1:0]    widx,
    input  logic [ADDR_W-1:0]          w_addr,
    input  logic [$clog2(M_BLK)-1:0]   w_nbr,
    input  logic [M_BLK-2:0]           w_flags,
    input  logic [M_BLK*$clog2(N_INSN)-1:0] w_bend,
    input  logic [(M_BLK-1)*ADDR_W-1:0] w_alt,
    input  logic [ADDR_W-1:0]          w_cont,
    input  logic [N_INSN*INSN_W-1:0]   w_data,
    input  logic [$clog2(SETS)-1:0]    ridx,
    output logic                       r_valid,
    output logic [ADDR_W-1:0]          r_addr,
    output logic [$clog2(M_BLK)-1:0]   r_nbr,
    output logic [M_BLK-2:0]           r_flags,
    output logic [M_BLK*$clog2(N_INSN)-1:0] r_bend,
    output logic [(M_BLK-1)*ADDR_W-1:0] r_alt,
    output logic [ADDR_W-1:0]          r_cont,
    output logic [N_INSN*INSN_W-1:0]   r_data,
    input  logic [$clog2(SETS)-1:0]    pidx,
    output logic                       p_valid,
    output logic [ADDR_W-1:0]          p_addr,
    output logic [$clog2(M_BLK)-1:0]   p_nbr,
    output logic [M_BLK-2:0]           p_flags
);
    localparam int POS_W = $clog2(N_INSN);
    localparam int NBR_W = $clog2(M_BLK);
    localparam int BR    = M_BLK - 1;

    logic [SETS-1:0]           vld;
    logic [ADDR_W-1:0]         tag_m  [SETS];
    logic [NBR_W-1:0]          nbr_m  [SETS];
    logic [BR-1:0]             flg_m  [SETS];
    logic [M_BLK*POS_W-1:0]    bend_m [SETS];
    logic [BR*ADDR_W-1:0]      alt_m  [SETS];
    logic [ADDR_W-1:0]         cont_m [SETS];
    logic [N_INSN*INSN_W-1:0]  data_m [SETS];

    // Valid bits: cleared by reset, set by a line write.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else if (we) vld[widx] <= 1'b1;
    end

    // Line payload: written whole, never reset.
    always_ff @(posedge clk) begin
        if (we) begin
            tag_m[widx]  <= w_addr;
            nbr_m[widx]  <= w_nbr;
            flg_m[widx]  <= w_flags;
            bend_m[widx] <= w_bend;
            alt_m[widx]  <= w_alt;
            cont_m[widx] <= w_cont;
            data_m[widx] <= w_data;
        end
    end

    // Lookup read port.
    always_comb begin
        r_valid = vld[ridx];
        r_addr  = tag_m[ridx];
        r_nbr   = nbr_m[ridx];
        r_flags = flg_m[ridx];
        r_bend  = bend_m[ridx];
        r_alt   = alt_m[ridx];
        r_cont  = cont_m[ridx];
        r_data  = data_m[ridx];
    end

    // Probe read port for fill placement.
    always_comb begin
        p_valid = vld[pidx];
        p_addr  = tag_m[pidx];
        p_nbr   = nbr_m[pidx];
        p_flags = flg_m[pidx];
    end

    // R9: a written line is valid from the next cycle on.
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> vld[$past(widx)]);
endmodule

// File: rtl/tc_match.sv
// Path comparison for one way: finds the first mismatching branch
// among the line's own branches and derives the delivered length,
// the next fetch address and a ranking score.
// Assumes: stored branch count <= M_BLK-1.
module tc_match #(
    parameter int ADDR_W = 32,
    parameter int N_INSN = 16,
    parameter int M_BLK  = 3
) (
    input  logic                           valid,
    input  logic [ADDR_W-1:0]              tag,
    input  logic [$clog2(M_BLK)-1:0]       nbr,
    input  logic [M_BLK-2:0]               flags,
    input  logic [M_BLK*$clog2(N_INSN)-1:0] bend,
    input  logic [(M_BLK-1)*ADDR_W-1:0]    alt,
    input  logic [ADDR_W-1:0]              cont,
    input  logic [ADDR_W-1:0]              lk_addr,
    input  logic [M_BLK-2:0]               lk_pred,
    output logic                           hit,
    output logic                           full,
    output logic [$clog2(M_BLK+1)-1:0]     score,
    output logic [$clog2(N_INSN+1)-1:0]    count,
    output logic [ADDR_W-1:0]              next
);
    localparam int POS_W = $clog2(N_INSN);
    localparam int CNT_W = $clog2(N_INSN+1);
    localparam int SC_W  = $clog2(M_BLK+1);
    localparam int BR    = M_BLK - 1;

    logic             mism;
    logic [SC_W-1:0]  nmatch;
    logic [POS_W-1:0] end_sel;

    // Walk the stored branches in order and stop at the first wrong one.
    always_comb begin
        mism    = 1'b0;
        nmatch  = SC_W'(nbr);
        end_sel = '0;
        next    = cont;
        for (int i = 0; i < BR; i++) begin
            if (!mism && i < int'(nbr) && flags[i] != lk_pred[i]) begin
                mism    = 1'b1;
                nmatch  = SC_W'(i);
                end_sel = bend[i*POS_W +: POS_W];
                next    = alt[i*ADDR_W +: ADDR_W];
            end
        end
        if (!mism) begin
            for (int b = 0; b < M_BLK; b++) begin
                if (b == int'(nbr)) end_sel = bend[b*POS_W +: POS_W];
            end
        end
    end

    // Hit class, score and delivered length.
    always_comb begin
        hit   = valid && (tag == lk_addr);
        full  = hit && !mism;
        score = full ? SC_W'(M_BLK) : nmatch;
        count = CNT_W'(end_sel) + CNT_W'(1);
    end
endmodule

// File: rtl/tc_select.sv
// Picks the winning way among matching ways: highest score wins,
// the lowest-numbered way wins a tie.
// Assumes: score of a full hit exceeds any partial score.
module tc_select #(
    parameter int WAYS = 2,
    parameter int SC_W = 2
) (
    input  logic [WAYS-1:0]      hit,
    input  logic [WAYS*SC_W-1:0] score,
    output logic                 any,
    output logic [$clog2(WAYS)-1:0] sel
);
    logic [SC_W-1:0] best;

    // Strict comparison keeps the earlier way on equal scores.
    always_comb begin
        any  = 1'b0;
        sel  = '0;
        best = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit[w] && (!any || score[w*SC_W +: SC_W] > best)) begin
                any  = 1'b1;
                sel  = $clog2(WAYS)'(w);
                best = score[w*SC_W +: SC_W];
            end
        end
    end
endmodule

// File: rtl/trace_path_cache.sv
// Trace cache with path matching. Two ways per set hold traces that may
// share a start address. A lookup answers one cycle later with a full
// hit, a prefix (partial hit) or a miss. Fills write a whole line in one
// cycle and yield to a same-set lookup.
// Assumes: fill fields are held while fill_ready is low; fill_nbr < M_BLK;
// block end indices ascend. The LRU bit per set presumes two ways.
module trace_path_cache #(
    parameter int ADDR_W = 32,
    parameter int INSN_W = 32,
    parameter int N_INSN = 16,
    parameter int M_BLK  = 3,
    parameter int SETS   = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               lk_valid,
    input  logic [ADDR_W-1:0]                  lk_addr,
    input  logic [M_BLK-2:0]                   lk_pred,
    output logic                               rsp_valid,
    output logic [1:0]                         rsp_kind,
    output logic [$clog2(N_INSN+1)-1:0]        rsp_count,
    output logic [ADDR_W-1:0]                  rsp_next,
    output logic [N_INSN*INSN_W-1:0]           rsp_insns,
    input  logic                               fill_valid,
    output logic                               fill_ready,
    input  logic [ADDR_W-1:0]                  fill_addr,
    input  logic [$clog2(M_BLK)-1:0]           fill_nbr,
    input  logic [M_BLK-2:0]                   fill_flags,
    input  logic [M_BLK*$clog2(N_INSN)-1:0]    fill_bend,
    input  logic [(M_BLK-1)*ADDR_W-1:0]        fill_alt,
    input  logic [ADDR_W-1:0]                  fill_cont,
    input  logic [N_INSN*INSN_W-1:0]           fill_insns
);
    import tc_pkg::*;

    localparam int WAYS  = 2;
    localparam int WSEL  = $clog2(WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int POS_W = $clog2(N_INSN);
    localparam int CNT_W = $clog2(N_INSN+1);
    localparam int NBR_W = $clog2(M_BLK);
    localparam int SC_W  = $clog2(M_BLK+1);
    localparam int BR    = M_BLK - 1;
    localparam int LINE_W = N_INSN*INSN_W;

    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic             fill_we;
    logic [WSEL-1:0]  victim;
    logic [SETS-1:0]  lru;

    logic [WAYS-1:0]        w_we, w_vld, w_hit, w_full, p_vld, p_same;
    logic [ADDR_W-1:0]      w_tag  [WAYS];
    logic [NBR_W-1:0]       w_nbr  [WAYS];
    logic [BR-1:0]          w_flg  [WAYS];
    logic [M_BLK*POS_W-1:0] w_bend [WAYS];
    logic [BR*ADDR_W-1:0]   w_alt  [WAYS];
    logic [ADDR_W-1:0]      w_cont [WAYS];
    logic [ADDR_W-1:0]      p_tag  [WAYS];
    logic [NBR_W-1:0]       p_nbr  [WAYS];
    logic [BR-1:0]          p_flg  [WAYS];
    logic [WAYS*LINE_W-1:0] data_flat;
    logic [WAYS*SC_W-1:0]   score_flat;
    logic [WAYS*CNT_W-1:0]  cnt_flat;
    logic [WAYS*ADDR_W-1:0] next_flat;
    logic                   any_hit;
    logic [WSEL-1:0]        sel;

    // Set selection from word-aligned address bits.
    always_comb begin
        lk_idx = lk_addr[2 +: IDX_W];
        fl_idx = fill_addr[2 +: IDX_W];
    end

    // A same-set lookup holds the fill back for this cycle.
    always_comb begin
        fill_ready = !(lk_valid && lk_idx == fl_idx);
        fill_we    = fill_valid && fill_ready;
    end

    // Per-way storage and path comparison.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign w_we[w] = fill_we && (victim == WSEL'(w));

        tc_way #(.SETS(SETS), .ADDR_W(ADDR_W), .INSN_W(INSN_W),
                 .N_INSN(N_INSN), .M_BLK(M_BLK)) u_way (
            .clk(clk), .rst_n(rst_n), .we(w_we[w]), .widx(fl_idx),
            .w_addr(fill_addr), .w_nbr(fill_nbr), .w_flags(fill_flags),
            .w_bend(fill_bend), .w_alt(fill_alt), .w_cont(fill_cont),
            .w_data(fill_insns),
            .ridx(lk_idx), .r_valid(w_vld[w]), .r_addr(w_tag[w]),
            .r_nbr(w_nbr[w]), .r_flags(w_flg[w]), .r_bend(w_bend[w]),
            .r_alt(w_alt[w]), .r_cont(w_cont[w]),
            .r_data(data_flat[w*LINE_W +: LINE_W]),
            .pidx(fl_idx), .p_valid(p_vld[w]), .p_addr(p_tag[w]),
            .p_nbr(p_nbr[w]), .p_flags(p_flg[w]));

        tc_match #(.ADDR_W(ADDR_W), .N_INSN(N_INSN), .M_BLK(M_BLK)) u_match (
            .valid(w_vld[w]), .tag(w_tag[w]), .nbr(w_nbr[w]),
            .flags(w_flg[w]), .bend(w_bend[w]), .alt(w_alt[w]),
            .cont(w_cont[w]), .lk_addr(lk_addr), .lk_pred(lk_pred),
            .hit(w_hit[w]), .full(w_full[w]),
            .score(score_flat[w*SC_W +: SC_W]),
            .count(cnt_flat[w*CNT_W +: CNT_W]),
            .next(next_flat[w*ADDR_W +: ADDR_W]));

        // Fill targets the same path when it is already present.
        always_comb begin
            p_same[w] = p_vld[w] && p_tag[w] == fill_addr && p_nbr[w] == fill_nbr;
            for (int i = 0; i < BR; i++) begin
                if (i < int'(fill_nbr) && p_flg[w][i] != fill_flags[i]) p_same[w] = 1'b0;
            end
        end
    end

    tc_select #(.WAYS(WAYS), .SC_W(SC_W)) u_sel (
        .hit(w_hit), .score(score_flat), .any(any_hit), .sel(sel));

    // Fill placement: same path, else first empty way, else LRU way.
    always_comb begin
        if (p_same[0])      victim = 1'b0;
        else if (p_same[1]) victim = 1'b1;
        else if (!p_vld[0]) victim = 1'b0;
        else if (!p_vld[1]) victim = 1'b1;
        else                victim = lru[fl_idx];
    end

    // Recency: lru holds the way to replace next in each set.
    always_ff @(posedge clk) begin
        if (!rst_n) lru <= '0;
        else begin
            if (lk_valid && any_hit) lru[lk_idx] <= ~sel;
            if (fill_we)             lru[fl_idx] <= ~victim;
        end
    end

    // Registered response with the unused slots forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= TC_MISS;
            rsp_count <= '0;
            rsp_next  <= '0;
            rsp_insns <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                if (any_hit) begin
                    rsp_kind  <= w_full[sel] ? TC_FULL : TC_PART;
                    rsp_count <= cnt_flat[int'(sel)*CNT_W +: CNT_W];
                    rsp_next  <= next_flat[int'(sel)*ADDR_W +: ADDR_W];
                    for (int s = 0; s < N_INSN; s++) begin
                        rsp_insns[s*INSN_W +: INSN_W] <=
                            (s < int'(cnt_flat[int'(sel)*CNT_W +: CNT_W]))
                            ? data_flat[int'(sel)*LINE_W + s*INSN_W +: INSN_W]
                            : '0;
                    end
                end else begin
                    rsp_kind  <= TC_MISS;
                    rsp_count <= '0;
                    rsp_next  <= lk_addr;
                    rsp_insns <= '0;
                end
            end
        end
    end

    // R5: a miss carries no instructions and points back at the request.
    a_r5_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !any_hit |=> rsp_count == '0 && rsp_next == $past(lk_addr));

    // R3: any hit delivers between one and N_INSN instructions.
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind != TC_MISS |-> rsp_count != '0 && int'(rsp_count) <= N_INSN);

    // R7: the chosen way never ranks below the other matching way.
    a_r7_best_way: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit && w_hit[~sel] |->
            score_flat[int'(sel)*SC_W +: SC_W] >= score_flat[int'(~sel)*SC_W +: SC_W]);

    // R9: a lookup hit leaves the other way as the next victim.
    a_r9_lru_touch: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && any_hit |=> lru[$past(lk_idx)] != $past(sel));

    // R10: a stalled fill is held steady by the producer.
    a_r10_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !fill_ready |=> fill_valid && $stable(fill_addr));
endmodule

// File: tb/trace_path_cache_bench.sv
module trace_path_cache_bench;
    localparam int AW = 32, IW = 32, NI = 16, MB = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic [1:0] lk_pred = '0;
    logic rsp_valid;
    logic [1:0] rsp_kind;
    logic [4:0] rsp_count;
    logic [AW-1:0] rsp_next;
    logic [NI*IW-1:0] rsp_insns;
    logic fill_valid = 1'b0, fill_ready;
    logic [AW-1:0] fill_addr = '0, fill_cont = '0;
    logic [1:0] fill_nbr = '0, fill_flags = '0;
    logic [11:0] fill_bend = '0;
    logic [2*AW-1:0] fill_alt = '0;
    logic [NI*IW-1:0] fill_insns = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trace_path_cache u_trace_path_cache (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_pred(lk_pred), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_count(rsp_count), .rsp_next(rsp_next), .rsp_insns(rsp_insns),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .fill_nbr(fill_nbr), .fill_flags(fill_flags), .fill_bend(fill_bend),
        .fill_alt(fill_alt), .fill_cont(fill_cont), .fill_insns(fill_insns));

    function automatic logic [31:0] word(input logic [31:0] a, input int i);
        return {a[15:0], 16'(i)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_fill(input logic [31:0] a, input logic [1:0] nbr,
                            input logic [1:0] flg, input logic [3:0] e0,
                            input logic [3:0] e1, input logic [3:0] e2,
                            input logic [31:0] a0, input logic [31:0] a1,
                            input logic [31:0] cont);
        fill_addr  = a;  fill_nbr = nbr; fill_flags = flg;
        fill_bend  = {e2, e1, e0};
        fill_alt   = {a1, a0};
        fill_cont  = cont;
        for (int i = 0; i < NI; i++) fill_insns[i*IW +: IW] = word(a, i);
    endtask

    // One-cycle fill with no competing lookup.
    task automatic do_fill(input logic [31:0] a, input logic [1:0] nbr,
                           input logic [1:0] flg, input logic [3:0] e0,
                           input logic [3:0] e1, input logic [3:0] e2,
                           input logic [31:0] a0, input logic [31:0] a1,
                           input logic [31:0] cont);
        @(negedge clk);
        put_fill(a, nbr, flg, e0, e1, e2, a0, a1, cont);
        fill_valid = 1'b1;
        #1;
        chk(fill_ready == 1'b1, "R10", "ready without conflict", 64'(fill_ready), 64'd1);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Lookup with checks of kind, count, next address and slot contents.
    task automatic look(input logic [31:0] a, input logic [1:0] pred,
                        input logic [1:0] kind, input int cnt,
                        input logic [31:0] nxt, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_pred = pred;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R1", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_kind == kind, req, "kind", 64'(rsp_kind), 64'(kind));
        chk(int'(rsp_count) == cnt, req, "count", 64'(rsp_count), 64'(cnt));
        chk(rsp_next == nxt, req, "next", 64'(rsp_next), 64'(nxt));
        if (cnt > 0) begin
            chk(rsp_insns[0 +: IW] == word(a, 0), "R12", "slot 0",
                64'(rsp_insns[0 +: IW]), 64'(word(a, 0)));
            chk(rsp_insns[(cnt-1)*IW +: IW] == word(a, cnt-1), "R12", "last slot",
                64'(rsp_insns[(cnt-1)*IW +: IW]), 64'(word(a, cnt-1)));
        end
        if (cnt < NI)
            chk(rsp_insns[cnt*IW +: IW] == '0, "R12", "slot past count",
                64'(rsp_insns[cnt*IW +: IW]), 64'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "no response without request", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        look(32'h100, 2'b01, 2'd0, 0, 32'h100, "R11");
    endtask

    task automatic t_full_and_prefix;
        do_fill(32'h100, 2'd2, 2'b01, 4'd3, 4'd8, 4'd13, 32'h500, 32'h600, 32'h700);
        look(32'h100, 2'b01, 2'd2, 14, 32'h700, "R2");
        look(32'h100, 2'b11, 2'd1, 9, 32'h600, "R3");
        look(32'h100, 2'b00, 2'd1, 4, 32'h500, "R3");
        look(32'h110, 2'b01, 2'd0, 0, 32'h110, "R5");
    endtask

    task automatic t_ignored_bits;
        do_fill(32'h204, 2'd0, 2'b00, 4'd5, 4'd0, 4'd0, 32'h0, 32'h0, 32'h900);
        do_fill(32'h104, 2'd1, 2'b10, 4'd2, 4'd10, 4'd0, 32'hA00, 32'h0, 32'hB00);
        look(32'h204, 2'b11, 2'd2, 6, 32'h900, "R4");
        look(32'h204, 2'b00, 2'd2, 6, 32'h900, "R4");
        look(32'h104, 2'b10, 2'd2, 11, 32'hB00, "R4");
        look(32'h104, 2'b01, 2'd1, 3, 32'hA00, "R4");
    endtask

    task automatic t_two_paths;
        do_fill(32'h100, 2'd2, 2'b11, 4'd3, 4'd6, 4'd15, 32'h510, 32'h610, 32'h710);
        look(32'h100, 2'b11, 2'd2, 16, 32'h710, "R6");
        look(32'h100, 2'b01, 2'd2, 14, 32'h700, "R6");
        look(32'h100, 2'b10, 2'd1, 4, 32'h500, "R7");
    endtask

    task automatic t_replace;
        // Last hit was way 0, so the way-1 path is evicted.
        do_fill(32'h100, 2'd2, 2'b10, 4'd1, 4'd2, 4'd3, 32'h520, 32'h620, 32'h720);
        look(32'h100, 2'b11, 2'd1, 9, 32'h600, "R9");
        look(32'h100, 2'b10, 2'd2, 4, 32'h720, "R9");
        look(32'h100, 2'b01, 2'd2, 14, 32'h700, "R9");
        do_fill(32'h100, 2'd2, 2'b11, 4'd3, 4'd6, 4'd15, 32'h510, 32'h610, 32'h710);
        look(32'h100, 2'b01, 2'd2, 14, 32'h700, "R9");
        // Recency now names way 1; a same-path fill still lands on way 0.
        do_fill(32'h100, 2'd2, 2'b01, 4'd3, 4'd8, 4'd13, 32'h500, 32'h600, 32'h7F0);
        look(32'h100, 2'b11, 2'd2, 16, 32'h710, "R8");
        look(32'h100, 2'b01, 2'd2, 14, 32'h7F0, "R8");
    endtask

    task automatic t_rank;
        do_fill(32'h108, 2'd2, 2'b10, 4'd2, 4'd5, 4'd9, 32'h540, 32'h640, 32'h740);
        do_fill(32'h108, 2'd2, 2'b11, 4'd4, 4'd7, 4'd11, 32'h550, 32'h630, 32'h730);
        look(32'h108, 2'b01, 2'd1, 8, 32'h630, "R7");
        look(32'h108, 2'b00, 2'd1, 6, 32'h640, "R7");
        look(32'h108, 2'b11, 2'd2, 12, 32'h730, "R7");
    endtask

    task automatic t_collision;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h100; lk_pred = 2'b01;
        put_fill(32'h300, 2'd0, 2'b00, 4'd7, 4'd0, 4'd0, 32'h0, 32'h0, 32'h800);
        fill_valid = 1'b1;
        #1;
        chk(fill_ready == 1'b0, "R10", "fill held on same set", 64'(fill_ready), 64'd0);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_kind == 2'd2 && rsp_next == 32'h7F0, "R10", "lookup wins",
            64'(rsp_next), 64'h7F0);
        #1;
        chk(fill_ready == 1'b1, "R10", "fill accepted next cycle", 64'(fill_ready), 64'd1);
        @(negedge clk);
        fill_valid = 1'b0;
        look(32'h300, 2'b00, 2'd2, 8, 32'h800, "R10");
        look(32'h100, 2'b11, 2'd1, 9, 32'h600, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_and_prefix();
        t_ignored_bits();
        t_two_paths();
        t_replace();
        t_rank();
        t_collision();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule